// File: doc/BRIEF.md
# Line-Stride DMA Address Generator

This block turns the payload description of one DMA descriptor into a stream of memory read requests, each an address and a byte length. A one-cycle start pulse loads the transfer size, the walk mode and the geometry. The block then issues requests one at a time until the payload is covered. After that it gives a one-cycle completion pulse, or a one-cycle error pulse if the walk was aborted.

In line mode the block reads fixed-size lines whose start addresses are a programmable stride apart. It stops once the line count covers the transfer size. In fragment mode it visits up to five independent buffers in order. Each read runs from the buffer's address to the next 4 KiB page boundary, and the last read is clipped to the bytes still owed. The walk also ends after the fifth buffer, even if bytes remain.

Requests leave over a valid/ready handshake. A request is taken on a clock edge where both valid and ready are high. While ready is low, valid stays high and the address and length do not change. The downstream side may hold ready low for any number of cycles. A read-error input from the memory side cancels the rest of the walk.

Top module: `stride_req_gen`

## Requirements
- R1: After reset, req_valid_o, done_o and err_o are all low.
- R2: In line mode (walk_frag_i = 0), request k has address base_addr_i + k*line_stride_i and length line_size_i. The walk continues while the remaining size exceeds zero. Each accepted request reduces the remaining size by line_size_i, saturating at zero, so the final line may extend past the transfer size.
- R3: In fragment mode (walk_frag_i = 1), fragment k is taken from frag_addr_i[k*48 +: 48], with fragments used in the order 0, 1, 2, and so on. Each request's length is 4096 minus (address mod 4096), clipped to the remaining size. Each accepted request reduces the remaining size by its length.
- R4: In fragment mode the walk ends after the request for fragment 4 (the fifth fragment) is accepted, even if bytes remain.
- R5: While req_valid_o is high and req_ready_i is low, with no read error, req_valid_o stays high and req_addr_o and req_len_o stay unchanged in the next cycle.
- R6: done_o is high for exactly one cycle, the cycle after the edge that accepts the last request. It is never high together with err_o.
- R7: rd_err_i high during a walk ends the walk. In the next cycle req_valid_o is low and err_o is high for one cycle, and no further requests or done_o follow.
- R8: A start in line mode with line_size_i = 0 issues no request and raises err_o in the cycle after the start.
- R9: A start with xfer_size_i = 0 and a usable geometry issues no request and raises done_o in the cycle after the start.
- R10: start_i during a walk is ignored, and the walk in progress keeps its sequence. rd_err_i while idle is ignored, and err_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that loads a descriptor payload walk |
| walk_frag_i | input | 1 | 0 = line mode, 1 = fragment mode |
| xfer_size_i | input | 32 | Payload size in bytes |
| line_size_i | input | 18 | Bytes per line (line mode) |
| line_stride_i | input | 22 | Byte distance between line starts (line mode) |
| base_addr_i | input | 48 | First line address (line mode) |
| frag_addr_i | input | 240 | Five 48-bit fragment addresses, fragment k at bits k*48 |
| req_valid_o | output | 1 | Request is presented |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_addr_o | output | 48 | Request byte address |
| req_len_o | output | 18 | Request length in bytes |
| rd_err_i | input | 1 | Memory-side read error, aborts the walk |
| done_o | output | 1 | One-cycle pulse: walk completed |
| err_o | output | 1 | One-cycle pulse: walk aborted or refused |

## Verification
The bench targets the final line that overshoots the transfer size. A design that subtracts without saturation would wrap the remaining count and never finish. It also covers fragment clipping on the last request, where a design that forgot to clip would read a whole page tail, and the stop after the fifth fragment, where a design that only counts bytes would run off the fragment list. Stalled ready is used to catch a request that changes while it waits. A start poked into a busy walk would corrupt the sequence on a design that reloads. A read error during a stall and a zero line size must each give an error pulse rather than a hang or a done pulse.

// File: rtl/stride_req_pkg.sv
package stride_req_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } walk_state_t;
endpackage

// File: rtl/srg_line_step.sv
module srg_line_step #(
  parameter int ADDR_W   = 48,
  parameter int LEN_W    = 18,
  parameter int SIZE_W   = 32,
  parameter int STRIDE_W = 22
) (
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic [SIZE_W-1:0]   rem_bytes,
  input  logic [LEN_W-1:0]    line_len,
  input  logic [STRIDE_W-1:0] stride,
  output logic [ADDR_W-1:0]   nxt_addr,
  output logic [SIZE_W-1:0]   nxt_rem,
  output logic                is_last
);
  logic [SIZE_W-1:0] line_ext;
  always_comb begin
    line_ext = SIZE_W'(line_len);
    nxt_addr = cur_addr + ADDR_W'(stride);
    is_last  = (rem_bytes <= line_ext);
    nxt_rem  = is_last ? '0 : rem_bytes - line_ext;
  end
endmodule

// File: rtl/srg_page_step.sv
module srg_page_step #(
  parameter int ADDR_W     = 48,
  parameter int LEN_W      = 18,
  parameter int SIZE_W     = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] frag_addr,
  input  logic [SIZE_W-1:0] rem_bytes,
  output logic [LEN_W-1:0]  req_len,
  output logic [SIZE_W-1:0] nxt_rem,
  output logic              size_last
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  logic [PAGE_W:0]   span;
  logic [SIZE_W-1:0] span_ext;
  logic [SIZE_W-1:0] take;
  always_comb begin
    span      = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, frag_addr[PAGE_W-1:0]};
    span_ext  = SIZE_W'(span);
    take      = (rem_bytes < span_ext) ? rem_bytes : span_ext;
    req_len   = LEN_W'(take);
    nxt_rem   = rem_bytes - take;
    size_last = (nxt_rem == '0);
  end
endmodule

// File: rtl/srg_frag_mux.sv
module srg_frag_mux #(
  parameter int ADDR_W   = 48,
  parameter int NUM_FRAG = 5,
  localparam int IDX_W   = $clog2(NUM_FRAG)
) (
  input  logic [NUM_FRAG*ADDR_W-1:0] frag_flat,
  input  logic [IDX_W-1:0]           sel,
  output logic [ADDR_W-1:0]          addr
);
  logic [ADDR_W-1:0] slot [NUM_FRAG];
  for (genvar g = 0; g < NUM_FRAG; g++) begin : g_unpack
    assign slot[g] = frag_flat[g*ADDR_W +: ADDR_W];
  end
  always_comb begin
    addr = slot[0];
    for (int i = 1; i < NUM_FRAG; i++) begin
      if (sel == IDX_W'(i)) addr = slot[i];
    end
  end
endmodule

// File: rtl/stride_req_gen.sv
module stride_req_gen
  import stride_req_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LEN_W      = 18,
  parameter int SIZE_W     = 32,
  parameter int STRIDE_W   = 22,
  parameter int NUM_FRAG   = 5,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       walk_frag_i,
  input  logic [SIZE_W-1:0]          xfer_size_i,
  input  logic [LEN_W-1:0]           line_size_i,
  input  logic [STRIDE_W-1:0]        line_stride_i,
  input  logic [ADDR_W-1:0]          base_addr_i,
  input  logic [NUM_FRAG*ADDR_W-1:0] frag_addr_i,
  output logic                       req_valid_o,
  input  logic                       req_ready_i,
  output logic [ADDR_W-1:0]          req_addr_o,
  output logic [LEN_W-1:0]           req_len_o,
  input  logic                       rd_err_i,
  output logic                       done_o,
  output logic                       err_o
);
  localparam int IDX_W = $clog2(NUM_FRAG);

  walk_state_t               state_q;
  logic                      mode_q;
  logic [ADDR_W-1:0]         line_addr_q;
  logic [SIZE_W-1:0]         rem_q;
  logic [LEN_W-1:0]          line_len_q;
  logic [STRIDE_W-1:0]       stride_q;
  logic [IDX_W-1:0]          frag_idx_q;
  logic [NUM_FRAG*ADDR_W-1:0] frags_q;
  logic                      done_q, err_q;

  logic [ADDR_W-1:0] ln_nxt_addr;
  logic [SIZE_W-1:0] ln_nxt_rem;
  logic              ln_last;
  logic [ADDR_W-1:0] fr_addr;
  logic [LEN_W-1:0]  fr_len;
  logic [SIZE_W-1:0] fr_nxt_rem;
  logic              fr_size_last;
  logic              fr_last;
  logic              hs;

  srg_line_step #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .STRIDE_W(STRIDE_W)
  ) u_line (
    .cur_addr (line_addr_q),
    .rem_bytes(rem_q),
    .line_len (line_len_q),
    .stride   (stride_q),
    .nxt_addr (ln_nxt_addr),
    .nxt_rem  (ln_nxt_rem),
    .is_last  (ln_last)
  );

  srg_frag_mux #(
    .ADDR_W(ADDR_W), .NUM_FRAG(NUM_FRAG)
  ) u_mux (
    .frag_flat(frags_q),
    .sel      (frag_idx_q),
    .addr     (fr_addr)
  );

  srg_page_step #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_page (
    .frag_addr(fr_addr),
    .rem_bytes(rem_q),
    .req_len  (fr_len),
    .nxt_rem  (fr_nxt_rem),
    .size_last(fr_size_last)
  );

  assign fr_last     = fr_size_last || (frag_idx_q == IDX_W'(NUM_FRAG-1));
  assign req_valid_o = (state_q == ST_REQ);
  assign req_addr_o  = mode_q ? fr_addr : line_addr_q;
  assign req_len_o   = mode_q ? fr_len  : line_len_q;
  assign hs          = req_valid_o && req_ready_i;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= 1'b0;
      line_addr_q <= '0;
      rem_q       <= '0;
      line_len_q  <= '0;
      stride_q    <= '0;
      frag_idx_q  <= '0;
      frags_q     <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q      <= walk_frag_i;
            line_addr_q <= base_addr_i;
            rem_q       <= xfer_size_i;
            line_len_q  <= line_size_i;
            stride_q    <= line_stride_i;
            frag_idx_q  <= '0;
            frags_q     <= frag_addr_i;
            if (!walk_frag_i && line_size_i == '0) begin
              err_q <= 1'b1;
            end else if (xfer_size_i == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (rd_err_i) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else if (hs) begin
            if (mode_q) begin
              rem_q      <= fr_nxt_rem;
              frag_idx_q <= frag_idx_q + 1'b1;
              if (fr_last) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              rem_q       <= ln_nxt_rem;
              line_addr_q <= ln_nxt_addr;
              if (ln_last) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int ADDR_W     = 48,
  parameter int LEN_W      = 18,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [LEN_W-1:0]  req_len_o,
  input logic              rd_err_i,
  input logic              done_o,
  input logic              err_o,
  input logic              frag_mode
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i && !rd_err_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o)); // R5
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && rd_err_i |=> !req_valid_o && err_o && !done_o); // R7
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && frag_mode |-> (32'(req_addr_o[PAGE_W-1:0]) + 32'(req_len_o)) <= 32'(PAGE_BYTES)); // R3
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_len_o != '0); // R8
endmodule

bind stride_req_gen srg_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_addr_o (req_addr_o),
  .req_len_o  (req_len_o),
  .rd_err_i   (rd_err_i),
  .done_o     (done_o),
  .err_o      (err_o),
  .frag_mode  (mode_q)
);

// File: tb/sim_stride_req_gen.sv
`timescale 1ns/1ps
module sim_stride_req_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         walk_frag_i = 1'b0;
  logic [31:0]  xfer_size_i = '0;
  logic [17:0]  line_size_i = '0;
  logic [21:0]  line_stride_i = '0;
  logic [47:0]  base_addr_i = '0;
  logic [239:0] frag_addr_i = '0;
  logic         req_valid_o;
  logic         req_ready_i = 1'b0;
  logic [47:0]  req_addr_o;
  logic [17:0]  req_len_o;
  logic         rd_err_i = 1'b0;
  logic         done_o, err_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int ready_mode = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  logic [47:0] exp_addr_q[$];
  logic [17:0] exp_len_q[$];
  logic prev_hs = 1'b0, prev_start = 1'b0, prev_stall = 1'b0;
  logic [47:0] prev_addr;
  logic [17:0] prev_len;

  always #5 clk = ~clk;

  stride_req_gen u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      case (ready_mode)
        0: req_ready_i = 1'b1;
        1: req_ready_i = cyc[0];
        default: req_ready_i = 1'b0;
      endcase
    end
  end

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin // R5
          chk("R5 hold", req_valid_o && req_addr_o == prev_addr && req_len_o == prev_len,
              {req_addr_o, req_len_o}, {prev_addr, prev_len});
        end
        if (done_o) begin
          done_cnt = done_cnt + 1;
          chk("R6 done timing", prev_hs || prev_start, 0, 1);
        end
        if (err_o) err_cnt = err_cnt + 1;
        if (req_valid_o && req_ready_i && !rd_err_i) begin
          if (exp_addr_q.size() == 0) begin
            chk("R2/R3 unexpected request", 1'b0, req_addr_o, 0);
          end else begin
            automatic logic [47:0] ea = exp_addr_q.pop_front();
            automatic logic [17:0] el = exp_len_q.pop_front();
            chk("R2/R3 request", req_addr_o == ea && req_len_o == el,
                {req_addr_o, req_len_o}, {ea, el});
          end
        end
        prev_hs    = req_valid_o && req_ready_i && !rd_err_i;
        prev_start = start_i;
        prev_stall = req_valid_o && !req_ready_i && !rd_err_i;
        prev_addr  = req_addr_o;
        prev_len   = req_len_o;
      end
    end
  end

  // driver: compute expected sequence, then pulse start
  task automatic launch(input bit frag, input logic [31:0] size, input logic [17:0] line,
                        input logic [21:0] stride, input logic [47:0] base, input logic [239:0] fr);
    automatic longint rem = size;
    if (!frag && line != 0) begin
      automatic logic [47:0] a = base;
      while (rem > 0) begin
        exp_addr_q.push_back(a); exp_len_q.push_back(line);
        rem = (rem <= line) ? 0 : rem - line;
        a = a + 48'(stride);
      end
    end else if (frag) begin
      for (int k = 0; k < 5 && rem > 0; k++) begin
        automatic logic [47:0] a = fr[k*48 +: 48];
        automatic longint span = 4096 - (a % 4096);
        automatic longint l = (rem < span) ? rem : span;
        exp_addr_q.push_back(a); exp_len_q.push_back(18'(l));
        rem = rem - l;
      end
    end
    @(posedge clk); #2;
    walk_frag_i = frag; xfer_size_i = size; line_size_i = line;
    line_stride_i = stride; base_addr_i = base; frag_addr_i = fr;
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic wait_end(input string req, input bit exp_err);
    automatic int d0 = done_cnt, e0 = err_cnt, n = 0;
    while (done_cnt == d0 && err_cnt == e0 && n < 3000) begin
      @(posedge clk); n++;
    end
    repeat (3) @(negedge clk);
    chk({req, " end kind"}, exp_err ? (err_cnt == e0 + 1 && done_cnt == d0)
                                    : (done_cnt == d0 + 1 && err_cnt == e0),
        {done_cnt - d0, err_cnt - e0}, exp_err ? 1 : 2);
    chk({req, " all requests seen"}, exp_addr_q.size() == 0, exp_addr_q.size(), 0);
    chk({req, " idle after"}, !req_valid_o, req_valid_o, 0);
    exp_addr_q.delete(); exp_len_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", !req_valid_o && !done_o && !err_o, {req_valid_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 line mode, exact multiple, full-rate ready
    ready_mode = 0;
    launch(0, 256, 64, 128, 48'h1000, '0);
    wait_end("R2 exact", 0);
    // R2 final line overshoots, alternating ready
    ready_mode = 1;
    launch(0, 200, 64, 4000, 48'hABC0_0000_0010, '0);
    wait_end("R2 overshoot", 0);
    // R3 fragment mode with clip on last
    launch(1, 256 + 4096 + 100, 0, 0, 0,
           {48'h0, 48'h0, 48'h3800, 48'h2000, 48'h1_0000_0F00});
    wait_end("R3 clip", 0);
    // R4 stops after fifth fragment
    ready_mode = 0;
    launch(1, 100000, 0, 0, 0,
           {48'h5_0FF0, 48'h4_0800, 48'h3_0000, 48'h2_0FFF, 48'h1_0100});
    wait_end("R4 five frags", 0);
    // R8 zero line size
    launch(0, 64, 0, 16, 48'h40, '0);
    wait_end("R8 zero line", 1);
    // R9 zero size in both modes
    launch(0, 0, 32, 16, 48'h40, '0);
    wait_end("R9 zero size line", 0);
    launch(1, 0, 0, 0, 0, {5{48'h100}});
    wait_end("R9 zero size frag", 0);
    // R10 start during walk is ignored
    ready_mode = 2;
    launch(0, 96, 32, 64, 48'h8000, '0);
    repeat (2) @(posedge clk); #2;
    base_addr_i = 48'hFFFF; line_size_i = 8; start_i = 1'b1;
    @(posedge clk); #2; start_i = 1'b0;
    ready_mode = 0;
    wait_end("R10 busy start", 0);
    // R10 read error while idle
    begin
      automatic int e0 = err_cnt;
      @(posedge clk); #2; rd_err_i = 1'b1;
      @(posedge clk); #2; rd_err_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 idle rd_err", err_cnt == e0, err_cnt - e0, 0);
    end
    // R7 read error during a stalled walk, then R5 exercised by the stall
    ready_mode = 2;
    launch(0, 1024, 128, 128, 48'h20000, '0);
    exp_addr_q.delete(); exp_len_q.delete();
    repeat (3) @(posedge clk); #2;
    chk("R5 valid while stalled", req_valid_o && req_addr_o == 48'h20000, req_addr_o, 48'h20000);
    rd_err_i = 1'b1;
    @(posedge clk); #2; rd_err_i = 1'b0;
    ready_mode = 0;
    wait_end("R7 abort", 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule